// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that runs against an 8-bit period register. Counting is driven by an external clock-enable tick that arrives at one quarter of the system clock rate. That tick first passes through a selectable divider (1, 4 or 16). Whenever the counter equals the period value on a divided tick, the counter returns to zero and the block emits a one-cycle match pulse. A PWM unit can use this pulse as its time base.

The match events also feed a 4-bit postscaler. After a programmed number of matches, from 1 to 16, the postscaler sets a sticky interrupt flag. The host clears this flag with a dedicated strobe.

A small register port lets the host read and write the counter, the period and an 8-bit control register. Writes to the counter or to the control register restart both scaler chains from zero.

Top module: `period_timer`

## Requirements
- R1: Register addresses are 0 = counter, 1 = period and 2 = control. Address 3 reads as 0. Writes take effect on the clock edge where `bus_wr` is high, and the read data follows `bus_addr` combinationally.
- R2: After reset the counter is 0, the period is 0xFF, the control register is 0, the flag is 0 and the match pulse is 0.
- R3: Control bit 2 is the run enable, bits 1:0 are the prescale code and bits 6:3 are the postscale field. Bit 7 always reads 0, even after 0xFF is written.
- R4: The prescale code selects a divider: 00 = divide by 1, 01 = divide by 4, and 10 or 11 = divide by 16. The divider counts `tick_en` pulses only while the timer runs.
- R5: On a divided tick the counter increments by one. When the counter equals the period on a divided tick, it returns to 0 instead, and `match_pulse` is high for exactly the following clock cycle.
- R6: With postscale field N, the flag sets on the edge of the (N+1)th match after the scalers restart. From a counter of 0, this takes exactly R·(P+1)·(N+1) `tick_en` pulses, where R is the divider and P is the period.
- R7: With the enable bit at 0, `tick_en` pulses change neither the counter nor the scaler state.
- R8: A counter write or a control write clears both the prescaler and the postscaler counts. A control write leaves the counter value unchanged.
- R9: The flag stays at 1 until `flag_clr` is pulsed. If a flag set and `flag_clr` happen in the same cycle, the flag ends at 1.
- R10: A counter write wins over a same-cycle divided tick, so the written value is kept. The written value is compared against the period from the next divided tick onward.
- R11: A counter above the period keeps counting, wraps from 255 to 0 without a match, and matches on reaching the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable pulse, nominally one cycle in four |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| match_pulse | output | 1 | One-cycle pulse after each period match |

## Verification
The bench sweeps every prescale code against several periods and postscale values, including period 0. For each combination it checks that the flag is still low one tick before the arithmetic count and high exactly on it. A design with an off-by-one divider, postscale ratio or period compare fails these checks.

Directed cases then target the scaler clearing. A restart that did not clear the prescaler after a counter write, or the postscaler after a control write, would advance too early. A control write that disturbed the counter would show in the readback.

Further cases cover a write colliding with a tick, which a design would get wrong by incrementing the written value. They also cover a flag set colliding with a clear, where the flag would be lost, and a counter beyond the period, which would either match falsely on the wrap or stop.

// File: rtl/period_timer_pkg.sv
// Shared constants for the period-match timer: register addresses,
// control field positions and the prescale code decode.
package period_timer_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 4;
    localparam int POST_W = 4;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_PER  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_POST_LSB = 3;
    localparam logic [DATA_W-1:0] CTRL_MASK   = 8'h7F;
    localparam logic [DATA_W-1:0] PERIOD_INIT = 8'hFF;

    // Terminal count of the prescaler for a given code (ratio minus one).
    function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd0;
            2'b01:   return 4'd3;
            default: return 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/ptm_prescaler.sv
// Input divider. Counts enabled ticks and emits a pulse on the tick that
// reaches the terminal count. Assumes `last` is stable between clears.
module ptm_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] last,
    output logic             pulse
);
    logic [DIV_W-1:0] div_q;

    // A clear suppresses the pulse so a restart begins a fresh ratio.
    assign pulse = step && !clr && (div_q == last);

    // Divider state: reset or clear to zero, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= (div_q == last) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptm_counter.sv
// Main up-counter with period compare. A host write wins over a divided
// tick; equality on a divided tick returns the count to zero.
module ptm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         hit,
    output logic         match_q
);
    logic [W-1:0] cnt_q;

    assign cnt = cnt_q;
    assign hit = step && !wr && (cnt_q == period);

    // Count register: write, restart on match, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr) begin
            cnt_q <= wdata;
        end else if (hit) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered match strobe for the PWM time base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
        end
    end
endmodule

// File: rtl/ptm_postscaler.sv
// Match postscaler and sticky flag. Counts matches up to `last` and sets
// the flag on completion; the set wins over a same-cycle clear.
module ptm_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hit,
    input  logic [W-1:0] last,
    input  logic         flag_clr,
    output logic         flag
);
    logic [W-1:0] post_q;
    logic         done;

    assign done = hit && (post_q == last);

    // Match counter, cleared by host restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            post_q <= '0;
        end else if (hit) begin
            post_q <= done ? '0 : post_q + 1'b1;
        end
    end

    // Sticky flag: set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (done) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/period_timer.sv
// Top of the period-match timer. Holds the period and control registers,
// decodes host writes and chains prescaler, counter and postscaler.
// Assumes tick_en is a single-cycle enable at a fraction of clk.
module period_timer
    import period_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic              match_pulse
);
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnt_q;
    logic              wr_cnt, wr_per, wr_ctrl, scaler_clr;
    logic              run_en, pre_tick, hit;

    assign wr_cnt     = bus_wr && (bus_addr == ADDR_CNT);
    assign wr_per     = bus_wr && (bus_addr == ADDR_PER);
    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign scaler_clr = wr_cnt || wr_ctrl;
    assign run_en     = ctrl_q[CTRL_EN_BIT];

    // Period register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_INIT;
        end else if (wr_per) begin
            period_q <= bus_wdata;
        end
    end

    // Control register; the unimplemented top bit is masked on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
        end
    end

    ptm_prescaler #(.DIV_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (scaler_clr),
        .step  (tick_en && run_en),
        .last  (pre_last(ctrl_q[1:0])),
        .pulse (pre_tick)
    );

    ptm_counter #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_cnt),
        .wdata   (bus_wdata),
        .step    (pre_tick),
        .period  (period_q),
        .cnt     (cnt_q),
        .hit     (hit),
        .match_q (match_pulse)
    );

    ptm_postscaler #(.W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (scaler_clr),
        .hit      (hit),
        .last     (ctrl_q[CTRL_POST_LSB +: POST_W]),
        .flag_clr (flag_clr),
        .flag     (irq_flag)
    );

    // Read-data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CNT:  bus_rdata = cnt_q;
            ADDR_PER:  bus_rdata = period_q;
            ADDR_CTRL: bus_rdata = ctrl_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptm_checker.sv
// Temporal checks on the timer, bound into every period_timer instance.
module ptm_checker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    input  logic         flag,
    input  logic         flag_clr,
    input  logic         match_pulse
);
    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt) |=> (cnt == $past(cnt)));

    assert_match_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (cnt == '0));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata)));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));
endmodule

bind period_timer ptm_checker #(.W(8)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cnt      (wr_cnt),
    .en          (run_en),
    .cnt         (cnt_q),
    .wdata       (bus_wdata),
    .hit         (hit),
    .flag        (irq_flag),
    .flag_clr    (flag_clr),
    .match_pulse (match_pulse)
);

// File: tb/period_timer_tb.sv
module period_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag;
    logic       match_pulse;

    int checks = 0;
    int fails = 0;
    int mcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .match_pulse(match_pulse)
    );

    // Counts match pulses, each one cycle wide, sampled mid-cycle.
    always @(negedge clk) if (rst_n && match_pulse) mcount++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied from a negedge to the next.
    task automatic cyc(input logic t, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic c);
        tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d; flag_clr = c;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic tick();
        cyc(1'b1, 1'b0, 2'd0, 8'd0, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v, m0, k, ratio;
        int periods[3] = '{0, 1, 5};
        int posts[4] = '{0, 1, 3, 15};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(2'd0, v); check("R2 counter", v, 0);
        rd(2'd1, v); check("R2 period", v, 255);
        rd(2'd2, v); check("R2 control", v, 0);
        check("R2 flag", int'(irq_flag), 0);
        check("R2 match", int'(match_pulse), 0);

        // R1 map and R3 top bit
        wr(2'd1, 8'd77); rd(2'd1, v); check("R1 period rw", v, 77);
        rd(2'd3, v); check("R1 addr3 zero", v, 0);
        wr(2'd2, 8'hFB); rd(2'd2, v); check("R3 bit7 zero", v, 8'h7B);
        wr(2'd2, 8'h00);

        // R4/R5/R6 sweep: flag exactly at R*(P+1)*(N+1) ticks
        for (int pc = 0; pc < 4; pc++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int ni = 0; ni < 4; ni++) begin
                    ratio = (pc == 0) ? 1 : (pc == 1) ? 4 : 16;
                    k = ratio * (periods[pi] + 1) * (posts[ni] + 1);
                    wr(2'd2, 8'(posts[ni] << 3 | pc));
                    wr(2'd0, 8'd0);
                    wr(2'd1, 8'(periods[pi]));
                    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1);
                    m0 = mcount;
                    wr(2'd2, 8'(posts[ni] << 3 | 4 | pc));
                    repeat (k - 1) tick();
                    check("R6 flag before", int'(irq_flag), 0);
                    rd(2'd0, v); check("R5 count before", v, periods[pi]);
                    check("R4 matches before", mcount - m0, posts[ni]);
                    tick();
                    check("R6 flag at", int'(irq_flag), 1);
                    rd(2'd0, v); check("R5 count wraps", v, 0);
                    check("R5 matches at", mcount - m0, posts[ni] + 1);
                end
            end
        end

        // R7 disabled timer holds
        wr(2'd2, 8'h00); wr(2'd0, 8'd7);
        repeat (5) tick();
        rd(2'd0, v); check("R7 hold", v, 7);

        // R8 counter write clears prescaler
        wr(2'd1, 8'd200); wr(2'd2, 8'h05); wr(2'd0, 8'd10);
        repeat (3) tick();
        wr(2'd0, 8'd10);
        repeat (3) tick();
        rd(2'd0, v); check("R8 prescaler cleared", v, 10);
        tick();
        rd(2'd0, v); check("R8 prescaler count", v, 11);
        // R8 control write keeps counter
        wr(2'd2, 8'h05); rd(2'd0, v); check("R8 ctrl keeps counter", v, 11);

        // R8 control write clears postscaler
        wr(2'd2, 8'h00); wr(2'd1, 8'd0); wr(2'd0, 8'd0);
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1);
        wr(2'd2, 8'h0C);
        tick();
        wr(2'd2, 8'h0C);
        tick();
        check("R8 postscaler cleared", int'(irq_flag), 0);
        tick();
        check("R8 postscaler done", int'(irq_flag), 1);

        // R9 clear, then set colliding with clear
        cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1);
        check("R9 clear", int'(irq_flag), 0);
        tick();
        cyc(1'b1, 1'b0, 2'd0, 8'd0, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 set wins", int'(irq_flag), 1);
        repeat (4) @(negedge clk);
        check("R9 sticky", int'(irq_flag), 1);

        // R10 write beats tick; written value compared next tick
        wr(2'd2, 8'h00); wr(2'd1, 8'd50); wr(2'd2, 8'h04);
        cyc(1'b1, 1'b1, 2'd0, 8'd20, 1'b0);
        rd(2'd0, v); check("R10 write wins", v, 20);
        wr(2'd0, 8'd50);
        m0 = mcount;
        tick();
        rd(2'd0, v); check("R10 written compared", v, 0);
        check("R10 match count", mcount - m0, 1);

        // R11 wrap above period
        wr(2'd1, 8'd3); wr(2'd0, 8'd254);
        m0 = mcount;
        tick(); rd(2'd0, v); check("R11 to 255", v, 255);
        tick(); rd(2'd0, v); check("R11 wrap 0", v, 0);
        check("R11 no match on wrap", mcount - m0, 0);
        repeat (3) tick();
        rd(2'd0, v); check("R11 at period", v, 3);
        tick();
        rd(2'd0, v); check("R11 match reset", v, 0);
        check("R11 one match", mcount - m0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule